// File: doc/BRIEF.md
# Field Memory Power-Up Initializer

This block sits between a video datapath and a serial field memory that has independent write and read ports. After power is applied, the memory's address pointers hold no meaningful value. The block waits a programmable number of clock cycles so the supply can settle, then drives the memory's own bring-up order on both ports. It finishes by opening the memory ports to the datapath.

Each port is driven by three per-cycle controls. The first is a clock enable: a pulse on the memory's serial clock happens in every cycle where it is high. The second is the port enable, and the third is the pointer reset. In normal mode each port gets a dummy burst, with the clock and the enable both active, and then a single reset cycle. In recovery mode, used when the supply may not have been stable while the burst ran, each port gets a reset, then the burst, then a second reset. The write port and the read port run their sequences side by side in the same cycles.

Until both sequences have finished, the datapath's controls are held off the memory. Once `ready` is high, the memory controls follow the datapath controls combinationally. A synchronous restart reruns everything, starting again from the settling wait.

Top module: `fmi_init`

## Requirements
- R1: After reset is released, or in the cycle after `restart` is sampled high, `ready` and all six memory controls stay low for exactly STAB_CYCLES cycles.
- R2: In normal mode, the settling wait is followed by BURST_LEN cycles in which each port drives clock enable = 1, enable = 1 and reset = 0.
- R3: In normal mode, the burst is followed by exactly one cycle with clock enable = 1, enable = 0 and reset = 1 on each port. After that cycle, initialization is complete.
- R4: While `ready` is low, the write port controls (`mem_wck_en`, `mem_we`, `mem_wrst`) are equal to the read port controls (`mem_rck_en`, `mem_re`, `mem_rrst`) in every cycle.
- R5: In recovery mode, each port gets one reset cycle, then BURST_LEN burst cycles, then one more reset cycle. Each reset cycle has clock enable = 1 and enable = 0.
- R6: While `ready` is low, a reset cycle on a port is never preceded by a reset on that port in either of the two previous cycles.
- R7: `ready` rises in the cycle after a port's last reset cycle. It then stays high until `restart` or reset.
- R8: While `ready` is low, the datapath inputs have no effect on the memory controls. While `ready` is high, each memory control equals its datapath input in the same cycle.
- R9: `restart` aborts any phase of the sequence, including a burst in progress. The wait of R1 begins again.
- R10: `recovery_mode` is sampled only in the last cycle of the settling wait. Changes to it at any other time do not alter a sequence already in progress.
- R11: Elaboration fails if BURST_LEN is below 130 or if STAB_CYCLES is below 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous rerun of the whole sequence |
| recovery_mode | input | 1 | Selects the reset-burst-reset sequence |
| dp_wck_en | input | 1 | Datapath write clock enable |
| dp_we | input | 1 | Datapath write enable |
| dp_wrst | input | 1 | Datapath write pointer reset |
| dp_rck_en | input | 1 | Datapath read clock enable |
| dp_re | input | 1 | Datapath read enable |
| dp_rrst | input | 1 | Datapath read pointer reset |
| mem_wck_en | output | 1 | Write clock enable to the memory |
| mem_we | output | 1 | Write enable to the memory |
| mem_wrst | output | 1 | Write pointer reset to the memory |
| mem_rck_en | output | 1 | Read clock enable to the memory |
| mem_re | output | 1 | Read enable to the memory |
| mem_rrst | output | 1 | Read pointer reset to the memory |
| ready | output | 1 | Initialization complete, datapath owns the ports |

## Verification
A wrong settle counter or burst counter moves the edges of the enable pulses and the `ready` edge by whole cycles. Because the bench model predicts every cycle, such an error is reported on the first cycle that is off. A port sequencer in the wrong phase shows up at once as a reset without its clock pulse, or as a mismatch between the write and read controls. A select that is stuck makes datapath activity leak onto the memory, or be dropped, in the first cycle where the random datapath stimulus differs from the sequence.

// File: rtl/fmi_pkg.sv
`timescale 1ns/1ps
package fmi_pkg;

   localparam int FMI_MIN_BURST = 130;
   localparam int FMI_MIN_STAB  = 2;
   localparam int FMI_PORTS     = 2;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LEAD_RST,
      PH_BURST,
      PH_TAIL_RST,
      PH_DONE
   } fmi_phase_e;

   typedef struct packed {
      logic clk_en;
      logic en;
      logic rst;
   } fmi_ctl_t;

endpackage

// File: rtl/fmi_stab_timer.sv
`timescale 1ns/1ps
module fmi_stab_timer #(
   parameter int STAB_CYCLES = 10_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic start
);
   localparam int CW = $clog2(STAB_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

   logic [CW-1:0] cnt_q;
   logic          fired_q;

   assign start = !fired_q && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
      end else if (restart) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
      end else if (start) begin
         fired_q <= 1'b1;
      end else if (!fired_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/fmi_port_seq.sv
`timescale 1ns/1ps
module fmi_port_seq
   import fmi_pkg::*;
#(
   parameter int BURST_LEN = 130
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     restart,
   input  logic     start,
   input  logic     recovery,
   output fmi_ctl_t ctl,
   output logic     done
);
   localparam int BW = $clog2(BURST_LEN);
   localparam logic [BW-1:0] BLAST = BW'(BURST_LEN - 1);

   fmi_phase_e    ph_q, ph_d;
   logic [BW-1:0] bcnt_q;
   logic          burst_last;

   assign burst_last = (bcnt_q == BLAST);

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE:     if (start) ph_d = recovery ? PH_LEAD_RST : PH_BURST;
         PH_LEAD_RST: ph_d = PH_BURST;
         PH_BURST:    if (burst_last) ph_d = PH_TAIL_RST;
         PH_TAIL_RST: ph_d = PH_DONE;
         default:     ph_d = ph_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         bcnt_q <= '0;
      end else if (restart) begin
         ph_q   <= PH_IDLE;
         bcnt_q <= '0;
      end else begin
         ph_q   <= ph_d;
         bcnt_q <= (ph_q == PH_BURST) ? bcnt_q + 1'b1 : '0;
      end
   end

   always_comb begin
      ctl.clk_en = (ph_q == PH_LEAD_RST) || (ph_q == PH_BURST) || (ph_q == PH_TAIL_RST);
      ctl.en     = (ph_q == PH_BURST);
      ctl.rst    = (ph_q == PH_LEAD_RST) || (ph_q == PH_TAIL_RST);
   end

   assign done = (ph_q == PH_DONE);
endmodule

// File: rtl/fmi_port_mux.sv
`timescale 1ns/1ps
module fmi_port_mux
   import fmi_pkg::*;
(
   input  logic     sel_dp,
   input  fmi_ctl_t seq_ctl,
   input  fmi_ctl_t dp_ctl,
   output fmi_ctl_t mem_ctl
);
   assign mem_ctl = sel_dp ? dp_ctl : seq_ctl;
endmodule

// File: rtl/fmi_init.sv
`timescale 1ns/1ps
module fmi_init
   import fmi_pkg::*;
#(
   parameter int STAB_CYCLES = 10_000_000,
   parameter int BURST_LEN   = 130
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic recovery_mode,
   input  logic dp_wck_en,
   input  logic dp_we,
   input  logic dp_wrst,
   input  logic dp_rck_en,
   input  logic dp_re,
   input  logic dp_rrst,
   output logic mem_wck_en,
   output logic mem_we,
   output logic mem_wrst,
   output logic mem_rck_en,
   output logic mem_re,
   output logic mem_rrst,
   output logic ready
);
   // R11: parameter limits checked at elaboration
   if (BURST_LEN < FMI_MIN_BURST) begin : g_bad_burst
      $error("fmi_init: BURST_LEN %0d below minimum %0d", BURST_LEN, FMI_MIN_BURST);
   end
   if (STAB_CYCLES < FMI_MIN_STAB) begin : g_bad_stab
      $error("fmi_init: STAB_CYCLES %0d below minimum %0d", STAB_CYCLES, FMI_MIN_STAB);
   end

   logic                 start;
   fmi_ctl_t             dp_ctl  [FMI_PORTS];
   fmi_ctl_t             seq_ctl [FMI_PORTS];
   fmi_ctl_t             mem_ctl [FMI_PORTS];
   logic [FMI_PORTS-1:0] done;

   assign dp_ctl[0] = '{clk_en: dp_wck_en, en: dp_we, rst: dp_wrst};
   assign dp_ctl[1] = '{clk_en: dp_rck_en, en: dp_re, rst: dp_rrst};

   fmi_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .start   (start)
   );

   for (genvar p = 0; p < FMI_PORTS; p++) begin : g_port
      fmi_port_seq #(.BURST_LEN(BURST_LEN)) u_seq (
         .clk      (clk),
         .rst_n    (rst_n),
         .restart  (restart),
         .start    (start),
         .recovery (recovery_mode),
         .ctl      (seq_ctl[p]),
         .done     (done[p])
      );
      fmi_port_mux u_mux (
         .sel_dp  (ready),
         .seq_ctl (seq_ctl[p]),
         .dp_ctl  (dp_ctl[p]),
         .mem_ctl (mem_ctl[p])
      );
   end

   assign ready = &done;

   assign mem_wck_en = mem_ctl[0].clk_en;
   assign mem_we     = mem_ctl[0].en;
   assign mem_wrst   = mem_ctl[0].rst;
   assign mem_rck_en = mem_ctl[1].clk_en;
   assign mem_re     = mem_ctl[1].en;
   assign mem_rrst   = mem_ctl[1].rst;
endmodule

// File: rtl/fmi_init_chk.sv
`timescale 1ns/1ps
module fmi_init_chk (
   input logic clk,
   input logic rst_n,
   input logic restart,
   input logic ready,
   input logic mem_wck_en,
   input logic mem_we,
   input logic mem_wrst,
   input logic mem_rck_en,
   input logic mem_re,
   input logic mem_rrst
);
   a_r4_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (mem_wck_en == mem_rck_en && mem_we == mem_re && mem_wrst == mem_rrst));

   a_r3_reset_has_clock: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && mem_wrst) |-> (mem_wck_en && !mem_we));

   a_r6_wrst_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && mem_wrst) |-> (!$past(mem_wrst) && !$past(mem_wrst, 2)));

   a_r6_rrst_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && mem_rrst) |-> (!$past(mem_rrst) && !$past(mem_rrst, 2)));

   a_r7_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !restart) |=> ready);

   a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!ready && !mem_wck_en && !mem_rck_en));
endmodule

bind fmi_init fmi_init_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .restart    (restart),
   .ready      (ready),
   .mem_wck_en (mem_wck_en),
   .mem_we     (mem_we),
   .mem_wrst   (mem_wrst),
   .mem_rck_en (mem_rck_en),
   .mem_re     (mem_re),
   .mem_rrst   (mem_rrst)
);

// File: tb/fmi_init_bench.sv
`timescale 1ns/1ps
module fmi_init_bench;
   localparam int STAB  = 20;
   localparam int BURST = 130;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0, restart = 1'b0, recovery_mode = 1'b0;
   logic dp_wck_en = 0, dp_we = 0, dp_wrst = 0, dp_rck_en = 0, dp_re = 0, dp_rrst = 0;
   logic mem_wck_en, mem_we, mem_wrst, mem_rck_en, mem_re, mem_rrst, ready;

   fmi_init #(.STAB_CYCLES(STAB), .BURST_LEN(BURST)) u_fmi_init (
      .clk(clk), .rst_n(rst_n), .restart(restart), .recovery_mode(recovery_mode),
      .dp_wck_en(dp_wck_en), .dp_we(dp_we), .dp_wrst(dp_wrst),
      .dp_rck_en(dp_rck_en), .dp_re(dp_re), .dp_rrst(dp_rrst),
      .mem_wck_en(mem_wck_en), .mem_we(mem_we), .mem_wrst(mem_wrst),
      .mem_rck_en(mem_rck_en), .mem_re(mem_re), .mem_rrst(mem_rrst),
      .ready(ready)
   );

   int   t = 0;
   int   cyc = 0;
   logic mode_q = 1'b0;
   int   n_chk = 0, n_fail = 0;
   bit   finished = 0;
   int   last_wrst = -100, last_rrst = -100;

   // behavioural reference: cycles since reset or restart, latched mode
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n || restart) t <= 0;
      else t <= t + 1;
      if (rst_n && !restart && t == STAB - 1) mode_q <= recovery_mode;
   end

   function automatic logic exp_ready();
      int lim;
      lim = mode_q ? STAB + BURST + 1 : STAB + BURST;
      return rst_n && (t > lim);
   endfunction

   // expected {clk_en, en, rst} from the sequencer
   function automatic logic [2:0] exp_seq();
      int u;
      if (!rst_n || t < STAB) return 3'b000;
      u = t - STAB;
      if (!mode_q) begin
         if (u < BURST)  return 3'b110;
         if (u == BURST) return 3'b101;
         return 3'b000;
      end
      if (u == 0)          return 3'b101;
      if (u <= BURST)      return 3'b110;
      if (u == BURST + 1)  return 3'b101;
      return 3'b000;
   endfunction

   task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
      end
   endtask

   task automatic check_cycle();
      logic       er;
      logic [2:0] es, ew, erd, aw, ar;
      string      tag;
      er  = exp_ready();
      es  = exp_seq();
      ew  = er ? {dp_wck_en, dp_we, dp_wrst} : es;
      erd = er ? {dp_rck_en, dp_re, dp_rrst} : es;
      aw  = {mem_wck_en, mem_we, mem_wrst};
      ar  = {mem_rck_en, mem_re, mem_rrst};
      if (er)                      tag = "R8";
      else if (!rst_n || t < STAB) tag = "R1";
      else if (mode_q)             tag = "R5";
      else if (es == 3'b101)       tag = "R3";
      else                         tag = "R2";
      chk("R7", {2'b00, ready}, {2'b00, er});
      chk(tag, aw, ew);
      chk(tag, ar, erd);
      if (!er) chk("R4", aw, ar);
      if (!er && (dp_wck_en | dp_we | dp_wrst | dp_rck_en | dp_re | dp_rrst))
         chk("R8", aw, es);
      if (!er && rst_n && t >= STAB && recovery_mode != mode_q)
         chk("R10", aw, es);
      if (rst_n && t == 0 && cyc > 0)
         chk("R9", {ready, mem_wck_en, mem_rck_en}, 3'b000);
      if (!ready && mem_wrst) begin
         chk("R6", {2'b00, (cyc - last_wrst) >= 3}, 3'b001);
      end
      if (!ready && mem_rrst) begin
         chk("R6", {2'b00, (cyc - last_rrst) >= 3}, 3'b001);
      end
      if (mem_wrst) last_wrst = cyc;
      if (mem_rrst) last_rrst = cyc;
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check_cycle();
         restart = 1'b0;
         {dp_wck_en, dp_we, dp_wrst, dp_rck_en, dp_re, dp_rrst} = 6'($urandom);
      end
   endtask

   task automatic finish_run();
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      // normal mode after reset (R1 R2 R3 R7 R8)
      step(3);
      rst_n = 1'b1;
      step(250);
      // recovery mode via restart, mode changed mid-sequence (R5 R9 R10)
      recovery_mode = 1'b1;
      restart = 1'b1;
      step(30);
      recovery_mode = 1'b0;
      step(250);
      // restart during a burst (R9), then recovery again
      restart = 1'b1;
      step(70);
      recovery_mode = 1'b1;
      restart = 1'b1;
      step(60);
      recovery_mode = 1'b0;
      step(200);
      // asynchronous reset while ready
      rst_n = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(200);
      finish_run();
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all requirements): run did not end, actual hung expected done");
         finish_run();
      end
   end
endmodule